// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Ramp

This block sits in the digital path of a stereo audio converter, ahead of the interpolation stage. It multiplies every 24-bit two's-complement left and right sample by a shared gain. A mute request moves that gain between unity and zero in equal steps, one step per sample frame. Muting therefore fades the signal out over 1024 frames, and releasing the mute fades it back in, with no audible step.

The mute request is the OR of a dedicated pin and a control-register bit. A frame strobe moves the gain one step toward its target. If the request drops partway through a fade-out, the gain turns around at the level it has reached and climbs back to unity. Once the gain sits at zero, both outputs are exactly zero and a status flag is raised. While the outputs are held at zero, the format or filter settings can be changed without a click. A synchronous timing reset puts the gain at whichever end the current mute request points to.

Top module: `sm_softmute`

## Requirements
- R1: After the asynchronous reset `rstN` is released, the gain is unity, `fullyMuted` is 0 and `outValid` is 0.
- R2: At unity gain each output sample equals its input sample, including the full-scale values 0x7FFFFF and 0x800000.
- R3: While the mute request is high, each `frameStrobe` lowers the gain by one step of 1/1024. After 1024 strobes from unity, both outputs are exactly zero and `fullyMuted` is 1.
- R4: While the mute request is low, each `frameStrobe` raises the gain by one step from its current value, up to unity. `fullyMuted` drops as soon as the gain leaves zero.
- R5: When the request is released partway through a fade-out, the next strobes raise the gain from the level it had reached. They do not first finish the fade-out.
- R6: Each output is (input × gain count) / 1024, computed with signed arithmetic and rounded toward zero. For example, -3 at count 512 gives -1, and -5 at count 1 gives 0.
- R7: In any frame, the left and right channels use the same gain.
- R8: The gain count stays between 0 and 1024. A strobe at either end leaves it unchanged.
- R9: While `timingReset` is high, the gain is set on the next clock edge: to 0 if the mute request is high, and to unity if it is low.
- R10: The mute request is `muteFromPin` OR `muteFromReg`. Either input alone starts a fade-out.
- R11: Outputs are registered. `outValid` is high exactly one cycle after `sampleValid`. `outLeft` and `outRight` change only on that edge.
- R12: Without a `frameStrobe` or a `timingReset`, the gain does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timingReset | input | 1 | Synchronous timing reset: sets the gain to the end the mute request points to |
| muteFromPin | input | 1 | Mute request from the dedicated pin |
| muteFromReg | input | 1 | Mute request from the control-register bit |
| frameStrobe | input | 1 | One pulse per sample frame; moves the gain one step |
| sampleValid | input | 1 | Input sample pair is present |
| inLeft | input | 24 | Left input sample, two's complement |
| inRight | input | 24 | Right input sample, two's complement |
| outLeft | output | 24 | Scaled left sample |
| outRight | output | 24 | Scaled right sample |
| outValid | output | 1 | Scaled pair is present, one cycle after `sampleValid` |
| fullyMuted | output | 1 | The gain has reached zero |

## Verification
The step properties assume that the mute request and `timingReset` seen on a strobe cycle are the values that decide the step. The bench therefore changes the request only on a falling clock edge, and never on the same edge as a strobe. The properties also assume that `frameStrobe` is a single-cycle pulse. The bench spaces strobes at least one idle cycle apart, so each pulse is counted once. Samples are applied only after a strobe has settled, so every scaled value reflects a known gain count. A probe sample of ±2^22 turns each output into 4096 times the gain count, which lets the bench read the count through the ports.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int RAMP_LOG2 = 10;
  localparam int GAIN_W = RAMP_LOG2 + 1;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(2 ** RAMP_LOG2);

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic atFloor;
  } gain_bus_t;
endpackage

// File: rtl/sm_gain_ctrl.sv
module sm_gain_ctrl
  import sm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      timingReset,
  input  logic      muteReq,
  input  logic      frameStrobe,
  output gain_bus_t ctrlBus
);
  logic [GAIN_W-1:0] gainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainQ <= GAIN_UNITY;
    end else if (timingReset) begin
      gainQ <= muteReq ? '0 : GAIN_UNITY;
    end else if (frameStrobe) begin
      if (muteReq && gainQ != '0) begin
        gainQ <= gainQ - 1'b1;
      end else if (!muteReq && gainQ != GAIN_UNITY) begin
        gainQ <= gainQ + 1'b1;
      end
    end
  end

  always_comb begin
    ctrlBus.gain    = gainQ;
    ctrlBus.atFloor = (gainQ == '0);
  end
endmodule

// File: rtl/sm_scale_lane.sv
module sm_scale_lane
  import sm_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [GAIN_W-1:0] gain,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] sampleOut
);
  localparam int PROD_W = DATA_W + RAMP_LOG2;
  localparam int BIAS = 2 ** RAMP_LOG2 - 1;

  logic signed [PROD_W-1:0] sampleWide;
  logic signed [PROD_W-1:0] gainWide;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] biased;

  always_comb begin
    sampleWide = PROD_W'($signed(sampleIn));
    gainWide   = PROD_W'($signed({1'b0, gain}));
    product    = sampleWide * gainWide;
    // negative products get a bias so the shift truncates toward zero
    biased     = product + (product[PROD_W-1] ? PROD_W'(BIAS) : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else if (load) begin
      sampleOut <= biased[RAMP_LOG2 +: DATA_W];
    end
  end
endmodule

// File: rtl/sm_scale_dp.sv
module sm_scale_dp
  import sm_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CHANNELS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  gain_bus_t                      ctrlBus,
  input  logic                           sampleValid,
  input  logic [CHANNELS-1:0][DATA_W-1:0] samplesIn,
  output logic [CHANNELS-1:0][DATA_W-1:0] samplesOut,
  output logic                           outValid
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    sm_scale_lane #(.DATA_W(DATA_W)) u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .load      (sampleValid),
      .gain      (ctrlBus.gain),
      .sampleIn  (samplesIn[ch]),
      .sampleOut (samplesOut[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sampleValid;
  end
endmodule

// File: rtl/sm_softmute.sv
module sm_softmute
  import sm_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timingReset,
  input  logic              muteFromPin,
  input  logic              muteFromReg,
  input  logic              frameStrobe,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight,
  output logic              outValid,
  output logic              fullyMuted
);
  localparam int CHANNELS = 2;

  gain_bus_t ctrlBus;
  logic muteReq;
  logic [CHANNELS-1:0][DATA_W-1:0] samplesIn;
  logic [CHANNELS-1:0][DATA_W-1:0] samplesOut;

  assign muteReq   = muteFromPin | muteFromReg;
  assign samplesIn = {inRight, inLeft};
  assign outLeft   = samplesOut[0];
  assign outRight  = samplesOut[1];
  assign fullyMuted = ctrlBus.atFloor;

  sm_gain_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .timingReset (timingReset),
    .muteReq     (muteReq),
    .frameStrobe (frameStrobe),
    .ctrlBus     (ctrlBus)
  );

  sm_scale_dp #(.DATA_W(DATA_W), .CHANNELS(CHANNELS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlBus     (ctrlBus),
    .sampleValid (sampleValid),
    .samplesIn   (samplesIn),
    .samplesOut  (samplesOut),
    .outValid    (outValid)
  );
endmodule

// File: rtl/sm_softmute_chk.sv
module sm_softmute_chk
  import sm_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              timingReset,
  input logic              muteFromPin,
  input logic              muteFromReg,
  input logic              frameStrobe,
  input logic              sampleValid,
  input logic [DATA_W-1:0] outLeft,
  input logic [DATA_W-1:0] outRight,
  input logic              outValid,
  input gain_bus_t         ctrlBus
);
  logic muteAny;
  assign muteAny = muteFromPin | muteFromReg;

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !timingReset && muteAny && ctrlBus.gain != '0)
      |=> ctrlBus.gain == $past(ctrlBus.gain) - 1'b1);

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && !timingReset && !muteAny && ctrlBus.gain != GAIN_UNITY)
      |=> ctrlBus.gain == $past(ctrlBus.gain) + 1'b1);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStrobe && !timingReset) |=> $stable(ctrlBus.gain));

  assert_timing_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    timingReset |=> ctrlBus.gain == ($past(muteAny) ? '0 : GAIN_UNITY));

  assert_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ctrlBus.gain == '0) |=> (outLeft == '0 && outRight == '0));

  assert_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);

  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);

  always_comb begin
    if (rstN) assert_range_R8: assert (ctrlBus.gain <= GAIN_UNITY);
  end
endmodule

bind sm_softmute sm_softmute_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .timingReset (timingReset),
  .muteFromPin (muteFromPin),
  .muteFromReg (muteFromReg),
  .frameStrobe (frameStrobe),
  .sampleValid (sampleValid),
  .outLeft     (outLeft),
  .outRight    (outRight),
  .outValid    (outValid),
  .ctrlBus     (ctrlBus)
);

// File: tb/sm_softmute_bench.sv
module sm_softmute_bench;
  localparam int W = 24;
  localparam logic [W-1:0] PROBE_P = 24'sd4194304;
  localparam logic [W-1:0] PROBE_N = -24'sd4194304;

  typedef struct packed {
    logic [W-1:0] inL;
    logic [W-1:0] inR;
    logic [15:0]  steps;
    logic [W-1:0] expL;
    logic [W-1:0] expR;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{24'sd100,     -24'sd100,     16'd0,    24'sd100,     -24'sd100},
    '{24'sd8388607, -24'sd8388608, 16'd0,    24'sd8388607, -24'sd8388608},
    '{-24'sd3,      24'sd3,        16'd512,  -24'sd1,      24'sd1},
    '{24'sd1000,    -24'sd1000,    16'd1023, 24'sd0,       24'sd0},
    '{24'sd1024,    -24'sd1024,    16'd1023, 24'sd1,       -24'sd1},
    '{24'sd8388607, -24'sd8388608, 16'd1,    24'sd8380415, -24'sd8380416},
    '{-24'sd5,      24'sd5,        16'd1023, 24'sd0,       24'sd0},
    '{24'sd7,       -24'sd7,       16'd1024, 24'sd0,       24'sd0},
    '{24'sd3000,    -24'sd3000,    16'd256,  24'sd2250,    -24'sd2250},
    '{-24'sd1025,   24'sd1025,     16'd512,  -24'sd512,    24'sd512}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timingReset = 1'b0;
  logic muteFromPin = 1'b0;
  logic muteFromReg = 1'b0;
  logic frameStrobe = 1'b0;
  logic sampleValid = 1'b0;
  logic [W-1:0] inLeft = '0;
  logic [W-1:0] inRight = '0;
  logic [W-1:0] outLeft;
  logic [W-1:0] outRight;
  logic outValid;
  logic fullyMuted;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sm_softmute u_sm_softmute (
    .clk(clk), .rstN(rstN), .timingReset(timingReset),
    .muteFromPin(muteFromPin), .muteFromReg(muteFromReg),
    .frameStrobe(frameStrobe), .sampleValid(sampleValid),
    .inLeft(inLeft), .inRight(inRight),
    .outLeft(outLeft), .outRight(outRight),
    .outValid(outValid), .fullyMuted(fullyMuted)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frameStrobe = 1'b1;
      @(negedge clk) frameStrobe = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPair(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    inLeft = l; inRight = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic probeGain(input string tag, input int g);
    sendPair(PROBE_P, PROBE_N);
    check({tag, " valid"}, W'(outValid), W'(1));
    check({tag, " left"}, outLeft, W'(4096 * g));
    check({tag, " right"}, outRight, W'(-4096 * g));
  endtask

  task automatic pulseTimingReset();
    @(negedge clk) timingReset = 1'b1;
    @(negedge clk) timingReset = 1'b0;
  endtask

  initial begin
    #(150000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1: state after reset
    check("R1 fullyMuted", W'(fullyMuted), W'(0));
    check("R1 outValid", W'(outValid), W'(0));
    probeGain("R1 unity gain", 1024);
    // R11: valid drops the cycle after
    @(negedge clk);
    check("R11 valid single cycle", W'(outValid), W'(0));

    // vector table: gain set by timing reset then mute steps
    for (int v = 0; v < 10; v++) begin
      muteFromPin = 1'b0;
      pulseTimingReset();
      muteFromPin = 1'b1;
      strobes(int'(VECS[v].steps));
      muteFromPin = 1'b0;
      sendPair(VECS[v].inL, VECS[v].inR);
      // R2 for unity rows, R6 rounding for scaled rows, R7 both lanes
      check($sformatf("R6 R2 vec%0d left", v), outLeft, VECS[v].expL);
      check($sformatf("R7 vec%0d right", v), outRight, VECS[v].expR);
    end

    // R3: fade-out from unity via the pin
    pulseTimingReset();
    muteFromPin = 1'b1;
    strobes(1);
    probeGain("R3 first step", 1023);
    strobes(1022);
    check("R3 not yet muted", W'(fullyMuted), W'(0));
    strobes(1);
    check("R3 fullyMuted", W'(fullyMuted), W'(1));
    probeGain("R3 zero output", 0);
    strobes(3);
    probeGain("R8 floor saturates", 0);
    idle(20);
    probeGain("R12 hold at zero", 0);

    // R4: release climbs from zero
    muteFromPin = 1'b0;
    strobes(1);
    check("R4 flag drops", W'(fullyMuted), W'(0));
    strobes(299);
    probeGain("R4 climb", 300);
    idle(40);
    probeGain("R12 hold mid ramp", 300);
    strobes(724);
    probeGain("R4 reaches unity", 1024);
    strobes(2);
    probeGain("R8 ceiling saturates", 1024);

    // R10 and R5: register bit alone mutes; release mid fade-out reverses
    muteFromReg = 1'b1;
    strobes(400);
    probeGain("R10 register mute", 624);
    muteFromReg = 1'b0;
    strobes(10);
    probeGain("R5 reverses from level", 634);

    // R9: timing reset with mute high and low
    muteFromReg = 1'b1;
    pulseTimingReset();
    check("R9 flag on mute", W'(fullyMuted), W'(1));
    probeGain("R9 to zero", 0);
    muteFromReg = 1'b0;
    pulseTimingReset();
    probeGain("R9 to unity", 1024);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule